// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one byte per transfer over a four-wire serial link, either as the clock-driving master or as a slave that follows an external clock. A small register port lets a host write the byte to send, read the byte received, choose the mode and read or clear the status flags. The mode chooses the clock's idle level, the clock edge that captures data, whether bits travel most significant first, and whether the slave honours its select input.

In master mode, a data write starts a transfer. The serial clock runs at one quarter of the system clock for sixteen edges and then rests at its idle level. In slave mode, the external clock, select and data inputs pass through a two-stage synchronizer, and the block reacts to the edges it sees there. Data out changes on the edge opposite the capture edge. The first bit is on the line before the first capture edge. A one-cycle interrupt pulse marks a finished byte or a slave release.

If the host writes the data register while a byte is moving, the write is refused and a collision flag is latched. If a slave is released before its byte is complete, the bit count returns to zero and an incomplete flag is latched.

Top module: `spi_eng`

## Requirements
- R1: After reset, status (address 2) and received data (address 0) read 0, mode (address 1) reads 0, and `sclk_out` is high.
- R2: Mode bit 1 sets the idle clock level: 0 idles high, 1 idles low. `sclk_out` rests at that level while no master transfer runs.
- R3: Mode bit 2 selects the capture edge. With idle high, 0 captures on rising and 1 on falling. With idle low, 0 captures on falling and 1 on rising. Bytes are received and sent intact in every combination.
- R4: Mode bit 3 set sends and receives the most significant bit first. Clear, the least significant bit goes first.
- R5: In master mode (mode bit 0 set), a data write when idle produces exactly 16 clock edges, with rising edges 4 system clocks apart, and then the clock rests at its idle level.
- R6: After the eighth capture, status bit 0 (done) is set, the received byte reads at address 0, and `irq` pulses for one cycle. Writing 0 to status bit 0 clears done.
- R7: A data write while a byte is moving leaves the outgoing byte unchanged and sets status bit 1 (collision). Writing 0 to status bit 1 clears it.
- R8: With mode bit 4 set, a slave whose `sel_n` rises after 1 to 7 captured bits sets status bit 2 (incomplete) and pulses `irq`. Its bit count restarts, so the next selected byte is received intact.
- R9: With mode bit 4 clear, a slave ignores `sel_n` and receives with `sel_n` held high.
- R10: With mode bit 4 set and `sel_n` high, a slave ignores clock edges: no done flag, and the received data is unchanged.
- R11: The first outgoing bit is on `sdo` before the first capture edge in both edge orderings.
- R12: Writing 1 to a status flag bit leaves that flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select: 0 data, 1 mode, 2 status |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| sclk_in | input | 1 | Serial clock from an external master (slave mode) |
| sel_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | One-cycle pulse on a finished byte or a slave release |

## Verification
The hardest situation to reach from the ports is a host write that lands while a master byte is moving. To show the write was refused, the bench has to watch the bits that actually leave on `sdo`. The master-side driver therefore raises the write strobe from inside its edge-tracking loop, after the third capture edge. It then compares the whole outgoing byte and the collision flag. A slave released mid-byte is reached by stopping the serial clock after three bits. The bench raises `sel_n`, and a full byte follows to show the count restarted.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    // Mode register layout: [4] select enable, [3] msb first,
    // [2] edge select, [1] idle low, [0] master
    typedef struct packed {
        logic sel_use;
        logic msb_first;
        logic edge_sel;
        logic idle_low;
        logic master;
    } mode_t;

    // Status register layout: [2] incomplete, [1] collision, [0] done
    typedef struct packed {
        logic incomplete;
        logic collision;
        logic done;
    } flags_t;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2
    } reg_sel_e;

    localparam int MODE_W = $bits(mode_t);
    localparam int FLAG_W = $bits(flags_t);

    // Capture on rising edge: idle high with edge 0, or idle low with edge 1
    function automatic logic capture_on_rise(input mode_t m);
        return m.edge_sel ^ ~m.idle_low;
    endfunction

endpackage

// File: rtl/spi_eng_mclk.sv
module spi_eng_mclk #(
    parameter int DATA_W = 8,
    parameter int HALF   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic idle_low,
    output logic sclk,
    output logic tick_rise,
    output logic tick_fall,
    output logic active
);
    localparam int DW      = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int TOGGLES = 2 * DATA_W;
    localparam int TW      = $clog2(TOGGLES + 1);

    logic [DW-1:0] div_q;
    logic [TW-1:0] tog_q;
    logic          active_q;
    logic          sclk_q;
    logic          tick;

    assign tick      = active_q && (div_q == DW'(HALF - 1));
    assign tick_rise = tick && !sclk_q;
    assign tick_fall = tick && sclk_q;
    assign sclk      = sclk_q;
    assign active    = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= '0;
            tog_q    <= '0;
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
        end else if (!active_q) begin
            sclk_q <= ~idle_low;
            div_q  <= '0;
            tog_q  <= '0;
            if (start) active_q <= 1'b1;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                sclk_q <= ~sclk_q;
                tog_q  <= tog_q + 1'b1;
                if (tog_q == TW'(TOGGLES - 1)) active_q <= 1'b0;
            end
        end
    end

    // R5: two clock edges never fall in adjacent system cycles
    a_r5_edge_spacing: assert property (@(posedge clk) disable iff (rst)
        (HALF > 1) && tick |=> !tick);

    // R2: at rest the clock follows the idle level chosen one cycle earlier
    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !start) |=> (sclk_q == !$past(idle_low)));

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              dout,
    output logic              cnt_nz,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] tx_q, rx_q, rx_hold, rx_next;
    logic [CW-1:0]     cnt_q;
    logic              cap_rise, cap, launch, last;

    assign cap_rise   = capture_on_rise(mode);
    assign cap        = cap_rise ? rise : fall;
    assign launch     = cap_rise ? fall : rise;
    assign last       = cap && (cnt_q == CW'(DATA_W - 1));
    assign rx_next    = mode.msb_first ? {rx_q[DATA_W-2:0], din}
                                       : {din, rx_q[DATA_W-1:1]};
    assign dout       = mode.msb_first ? tx_q[DATA_W-1] : tx_q[0];
    assign cnt_nz     = (cnt_q != '0);
    assign done_pulse = last && !clr;
    assign rx_data    = rx_hold;

    // Transmit side: shift on launch edges once at least one bit was captured
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (!clr && launch && cnt_nz) begin
            tx_q <= mode.msb_first ? {tx_q[DATA_W-2:0], 1'b0}
                                   : {1'b0, tx_q[DATA_W-1:1]};
        end
    end

    // Receive side and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            rx_hold <= '0;
            cnt_q   <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cap) begin
            rx_q  <= rx_next;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            if (last) rx_hold <= rx_next;
        end
    end

    // R6: the completing capture restarts the count and publishes the byte
    a_r6_wrap_publish: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (cnt_q == '0) && (rx_hold == $past(rx_next)));

endmodule

// File: rtl/spi_eng.sv
module spi_eng
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF   = 2,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sclk_in,
    input  logic              sel_n,
    input  logic              sdi,
    output logic              sclk_out,
    output logic              sdo,
    output logic              irq
);
    mode_t  mode_q;
    flags_t flags_q;
    logic   irq_q;

    // Input synchronizers; clock and select rest high out of reset
    logic [SYNC-1:0] sclk_sy, sel_sy, sdi_sy;
    logic            sclk_prev, sel_prev, sclk_s, sel_s, sdi_s;

    assign sclk_s = sclk_sy[SYNC-1];
    assign sel_s  = sel_sy[SYNC-1];
    assign sdi_s  = sdi_sy[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy   <= '1;
            sel_sy    <= '1;
            sdi_sy    <= '0;
            sclk_prev <= 1'b1;
            sel_prev  <= 1'b1;
        end else begin
            sclk_sy   <= {sclk_sy[SYNC-2:0], sclk_in};
            sel_sy    <= {sel_sy[SYNC-2:0], sel_n};
            sdi_sy    <= {sdi_sy[SYNC-2:0], sdi};
            sclk_prev <= sclk_s;
            sel_prev  <= sel_s;
        end
    end

    // Host decode
    logic wr_data, wr_mode, wr_stat;
    assign wr_data = host_wr && (host_addr == REG_DATA);
    assign wr_mode = host_wr && (host_addr == REG_MODE);
    assign wr_stat = host_wr && (host_addr == REG_STAT);

    // Edge sources
    logic m_sclk, m_rise, m_fall, m_active;
    logic sel_ok, s_rise, s_fall, clr, desel_evt;
    logic rise, fall, din, cnt_nz, done_pulse, busy, load;
    logic [DATA_W-1:0] rx_data;

    assign sel_ok    = !mode_q.sel_use || !sel_s;
    assign s_rise    = !mode_q.master && sel_ok && sclk_s && !sclk_prev;
    assign s_fall    = !mode_q.master && sel_ok && !sclk_s && sclk_prev;
    assign clr       = !mode_q.master && mode_q.sel_use && sel_s;
    assign desel_evt = !mode_q.master && mode_q.sel_use && sel_s && !sel_prev;

    assign rise = mode_q.master ? m_rise : s_rise;
    assign fall = mode_q.master ? m_fall : s_fall;
    assign din  = mode_q.master ? sdi : sdi_s;
    assign busy = m_active || cnt_nz;
    assign load = wr_data && !busy;

    spi_eng_mclk #(.DATA_W(DATA_W), .HALF(HALF)) u_mclk (
        .clk       (clk),
        .rst       (rst),
        .start     (load && mode_q.master),
        .idle_low  (mode_q.idle_low),
        .sclk      (m_sclk),
        .tick_rise (m_rise),
        .tick_fall (m_fall),
        .active    (m_active)
    );

    spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .rise       (rise),
        .fall       (fall),
        .din        (din),
        .clr        (clr),
        .load       (load),
        .load_data  (host_wdata),
        .dout       (sdo),
        .cnt_nz     (cnt_nz),
        .done_pulse (done_pulse),
        .rx_data    (rx_data)
    );

    assign sclk_out = m_sclk;
    assign irq      = irq_q;

    // Registers and flags: a set event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= done_pulse || desel_evt;
            if (wr_mode) mode_q <= mode_t'(host_wdata[MODE_W-1:0]);
            if (wr_stat) begin
                if (!host_wdata[0]) flags_q.done       <= 1'b0;
                if (!host_wdata[1]) flags_q.collision  <= 1'b0;
                if (!host_wdata[2]) flags_q.incomplete <= 1'b0;
            end
            if (done_pulse)          flags_q.done       <= 1'b1;
            if (wr_data && busy)     flags_q.collision  <= 1'b1;
            if (desel_evt && cnt_nz) flags_q.incomplete <= 1'b1;
        end
    end

    always_comb begin
        case (host_addr)
            REG_DATA: host_rdata = rx_data;
            REG_MODE: host_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
            REG_STAT: host_rdata = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
            default:  host_rdata = '0;
        endcase
    end

    // R7: a refused data write latches the collision flag
    a_r7_collision_set: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> flags_q.collision);

    // R8: an early release latches incomplete and pulses the interrupt
    a_r8_incomplete_set: assert property (@(posedge clk) disable iff (rst)
        (desel_evt && cnt_nz) |=> (flags_q.incomplete && irq));

    // R10: a deselected slave holds its bit count at zero
    a_r10_deselected_idle: assert property (@(posedge clk) disable iff (rst)
        clr |=> !cnt_nz);

    // R12: collision survives any cycle without a zero written to its bit
    a_r12_collision_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.collision && !(wr_stat && !host_wdata[1])) |=> flags_q.collision);

endmodule

// File: tb/spi_eng_test.sv
module spi_eng_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sclk_in = 1'b1;
    logic       sel_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sclk_out, sdo, irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int irq_cnt = 0;
    logic [7:0] exp_q[$];

    bit g_msb, g_idle_low, g_cap_rise;

    spi_eng uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk_in(sclk_in),
        .sel_n(sel_n), .sdi(sdi), .sclk_out(sclk_out), .sdo(sdo), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [7:0] v, input int i, input bit msb);
        return msb ? v[7-i] : v[i];
    endfunction

    // Scoreboard monitor: each irq with an entry pending pops and compares
    always @(negedge clk) begin
        if (!rst && irq) begin
            irq_cnt++;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(host_rdata == e, "R6 received byte at irq", host_rdata, e);
            end
        end
    end

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 2'd0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_addr = 2'd0;
    endtask

    task automatic set_mode(input bit master, input bit idle_low, input bit edge_s,
                            input bit msb, input bit sel_use);
        host_write(2'd1, {3'b000, sel_use, msb, edge_s, idle_low, master});
        g_msb      = msb;
        g_idle_low = idle_low;
        g_cap_rise = idle_low ? edge_s : !edge_s;
        if (!master) sclk_in = !idle_low;
        repeat (6) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sv, input bit do_coll);
        int ncap = 0, ntog = 0, r1 = -1, r2 = -1;
        bit prev, sent = 0, wr_on = 0;
        logic [7:0] got = 8'd0;
        sdi = pick(sv, 0, g_msb);
        exp_q.push_back(sv);
        host_write(2'd0, tx);
        prev = sclk_out;
        for (int w = 0; w < 200 && ntog < 16; w++) begin
            @(negedge clk);
            if (wr_on) begin host_wr = 1'b0; wr_on = 0; end
            if (sclk_out != prev) begin
                ntog++;
                if (sclk_out) begin
                    if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
                end
                if (sclk_out == g_cap_rise) begin
                    got = g_msb ? {got[6:0], sdo} : {sdo, got[7:1]};
                    ncap++;
                end else if (ncap > 0 && ncap < 8) begin
                    sdi = pick(sv, ncap, g_msb);
                end
                prev = sclk_out;
            end
            if (do_coll && !sent && ncap == 3) begin
                host_addr = 2'd0; host_wdata = 8'h3C; host_wr = 1'b1;
                wr_on = 1; sent = 1;
            end
        end
        host_wr = 1'b0;
        chk(ntog == 16, "R5 sixteen clock edges", ntog, 16);
        chk(r2 - r1 == 4, "R5 rising edges four cycles apart", r2 - r1, 4);
        chk(got == tx, do_coll ? "R7 outgoing byte kept after refused write"
                               : "R3 R4 master outgoing byte", got, tx);
        repeat (4) @(negedge clk);
        chk(sclk_out == !g_idle_low, "R5 clock rests at idle after byte", sclk_out, !g_idle_low);
    endtask

    task automatic slave_xfer(input logic [7:0] sv, input logic [7:0] tx, input int nb,
                              input bit use_sel, input bit push, input bit chk_out);
        logic [7:0] got = 8'd0;
        bit cap_first = g_idle_low ? g_cap_rise : !g_cap_rise;
        if (push) exp_q.push_back(sv);
        if (use_sel) sel_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (!cap_first) begin sclk_in = !sclk_in; repeat (H) @(negedge clk); end
            sdi = pick(sv, i, g_msb);
            repeat (H) @(negedge clk);
            if (chk_out && i == 0)
                chk(sdo == pick(tx, 0, g_msb), "R11 first bit before first capture",
                    sdo, pick(tx, 0, g_msb));
            got = g_msb ? {got[6:0], sdo} : {sdo, got[7:1]};
            sclk_in = !sclk_in;
            repeat (H) @(negedge clk);
            if (cap_first) begin sclk_in = !sclk_in; repeat (H) @(negedge clk); end
        end
        if (chk_out && nb == 8) chk(got == tx, "R3 R4 slave outgoing byte", got, tx);
        sel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int ic;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        host_read(2'd2, r); chk(r == 8'h00, "R1 status after reset", r, 0);
        host_read(2'd0, r); chk(r == 8'h00, "R1 data after reset", r, 0);
        host_read(2'd1, r); chk(r == 8'h00, "R1 mode after reset", r, 0);
        chk(sclk_out == 1'b1, "R1 clock high after reset", sclk_out, 1);

        // Master, idle high, capture rising, msb first
        set_mode(1, 0, 0, 1, 0);
        chk(sclk_out == 1'b1, "R2 idle high", sclk_out, 1);
        master_xfer(8'hA5, 8'h3C, 0);
        host_read(2'd2, r); chk(r == 8'h01, "R6 done set after byte", r, 1);
        host_write(2'd2, 8'h06);
        host_read(2'd2, r); chk(r == 8'h00, "R6 done cleared by writing 0", r, 0);

        // Master, idle low, capture rising, lsb first
        set_mode(1, 1, 1, 0, 0);
        chk(sclk_out == 1'b0, "R2 idle low", sclk_out, 0);
        master_xfer(8'h96, 8'h1B, 0);

        // Master, idle low, capture falling, msb first
        set_mode(1, 1, 0, 1, 0);
        master_xfer(8'h71, 8'hE4, 0);

        // Master, idle high, capture falling, lsb first, with a collision
        set_mode(1, 0, 1, 0, 0);
        host_write(2'd2, 8'h00);
        master_xfer(8'hC3, 8'h5A, 1);
        host_read(2'd2, r); chk(r[1] == 1'b1, "R7 collision flag set", r[1], 1);
        host_write(2'd2, 8'h07);
        host_read(2'd2, r); chk(r == 8'h03, "R12 writing ones changes no flag", r, 3);
        host_write(2'd2, 8'h05);
        host_read(2'd2, r); chk(r == 8'h01, "R7 collision cleared by writing 0", r, 1);
        host_write(2'd2, 8'h00);

        // Slave, idle high, capture rising (launch first), msb first, select used
        set_mode(0, 0, 0, 1, 1);
        host_write(2'd0, 8'h4D);
        slave_xfer(8'hB2, 8'h4D, 8, 1, 1, 1);
        host_read(2'd2, r); chk(r == 8'h01, "R6 slave done set", r, 1);
        host_write(2'd2, 8'h00);

        // Slave, idle low, capture rising (capture first), lsb first, select used
        set_mode(0, 1, 1, 0, 1);
        host_write(2'd0, 8'h29);
        slave_xfer(8'h6E, 8'h29, 8, 1, 1, 1);
        host_write(2'd2, 8'h00);

        // R8 early release after three bits, then a full byte
        set_mode(0, 0, 0, 1, 1);
        ic = irq_cnt;
        slave_xfer(8'hFF, 8'h00, 3, 1, 0, 0);
        host_read(2'd2, r); chk(r == 8'h04, "R8 incomplete set, done clear", r, 4);
        chk(irq_cnt == ic + 1, "R8 irq pulse on release", irq_cnt, ic + 1);
        host_write(2'd2, 8'h00);
        host_write(2'd0, 8'h81);
        slave_xfer(8'h5F, 8'h81, 8, 1, 1, 1);
        host_read(2'd0, r); chk(r == 8'h5F, "R8 count restarted after release", r, 8'h5F);
        host_write(2'd2, 8'h00);

        // R10 select enabled, select held high: edges ignored
        slave_xfer(8'h11, 8'h00, 8, 0, 0, 0);
        host_read(2'd2, r); chk(r == 8'h00, "R10 no done while deselected", r, 0);
        host_read(2'd0, r); chk(r == 8'h5F, "R10 data unchanged while deselected", r, 8'h5F);

        // R9 select disabled, select held high: byte received
        set_mode(0, 0, 0, 1, 0);
        host_write(2'd0, 8'h3A);
        slave_xfer(8'h88, 8'h3A, 8, 0, 1, 1);
        host_read(2'd0, r); chk(r == 8'h88, "R9 byte received with select ignored", r, 8'h88);

        chk(exp_q.size() == 0, "R6 every expected byte seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule